// File: doc/BRIEF.md
# Character Row Attribute Buffer

This block keeps one text row's worth of per-column data on chip: for each of the 40 character columns it holds an 8-bit character pointer and a 4-bit colour attribute. On the first raster line of a row, the fetch logic places each fetched word on the data bus. The buffer stores each word in the column cell that is selected at that moment. On the remaining raster lines of the same row, the same cells are read back in column order, so the row is never fetched from memory a second time.

A column is selected by a single set bit in a shift register, not by a binary address and decoder. A row-start pulse puts the bit back on column 0. Each advance strobe moves it one column to the right. After the last column the bit leaves the register, and no cell is selected until the next row-start. Only the selected cell is touched in a given cycle. Its content is always driven on the output. When that cell is being written, the output shows the incoming bus word in the same cycle.

Top module: `line_cell_buffer`

## Requirements
- R1: After reset is released, column 0 is selected.
- R2: When `pix_ce` is high and `advance` is high (with `row_start` low), the selection moves from column k to column k+1 at the clock edge. At every moment at most one column is selected.
- R3: When `pix_ce` and `row_start` are both high, column 0 is selected at the next edge. This holds even if `advance` is also high.
- R4: When column NUM_CELLS-1 is selected and the selection advances, no column is selected. The selection stays empty through further advance strobes until `row_start`. While no column is selected, `cell_out` is all zero and fetch writes are ignored.
- R5: When `pix_ce` and `fetch_en` are high and a column is selected, `bus_data` is stored into that column at the clock edge. Bits [11:4] hold the character pointer and bits [3:0] hold the colour attribute, and both are stored and returned unchanged.
- R6: In a cycle that writes (R5), `cell_out` equals `bus_data` in that same cycle.
- R7: When `fetch_en` is low, `cell_out` shows the selected column's stored word, and the stored words do not change.
- R8: While `pix_ce` is low, the selection does not move and no cell is written, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Clock enable for one character-cycle step |
| fetch_en | input | 1 | Bus carries a fetched column word this cycle |
| row_start | input | 1 | Reload the selection to column 0 |
| advance | input | 1 | Move the selection one column on |
| bus_data | input | 12 | Fetched word: pointer [11:4], colour [3:0] |
| cell_out | output | 12 | Word of the selected column (write-through when writing) |

## Verification
The assertions take the input strobes as meaningful only when `pix_ce` is high. They also expect `row_start` and `advance` never to arrive more than once per enabled cycle. The stimulus changes inputs only on the falling edge, so every enabled cycle carries exactly one decision.

Writes go only to columns that are selected, and every cell that is read back has been written before in the run. The readback checks therefore never meet the uninitialised content of the storage. The end-of-row case is reached by advancing past the last column with fetch still active, so the ignored write and the zero output are both visible on `cell_out`.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
  localparam int PTR_W  = 8;
  localparam int ATTR_W = 4;
  localparam int WORD_W = PTR_W + ATTR_W;

  typedef struct packed {
    logic [PTR_W-1:0]  ptr;
    logic [ATTR_W-1:0] attr;
  } cell_word_t;
endpackage

// File: rtl/lcb_token_ring.sv
module lcb_token_ring #(
  parameter int NUM_CELLS = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic                 restart,
  input  logic                 step,
  output logic [NUM_CELLS-1:0] token
);
  logic [NUM_CELLS-1:0] token_q, token_d;
  localparam logic [NUM_CELLS-1:0] FIRST = {{(NUM_CELLS-1){1'b0}}, 1'b1};

  always_comb begin
    token_d = token_q;
    if (ce) begin
      if (restart)   token_d = FIRST;
      else if (step) token_d = token_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) token_q <= FIRST;
    else        token_q <= token_d;
  end

  assign token = token_q;

  // R2: at most one column selected
  a_r2_token_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(token_q));
  // R2: one column per enabled advance
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    ce && step && !restart |=> token_q == ($past(token_q) << 1));
  // R3: restart selects column 0
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ce && restart |=> token_q == FIRST);
  // R4: empty selection stays empty without restart
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (token_q == '0) && !(ce && restart) |=> token_q == '0);
  // R8: no movement while disabled
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(token_q));
endmodule

// File: rtl/lcb_cell_array.sv
module lcb_cell_array
  import lcb_pkg::*;
#(
  parameter int NUM_CELLS = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_CELLS-1:0] sel,
  input  cell_word_t           wr_word,
  output cell_word_t           rd_word
);
  cell_word_t mem [NUM_CELLS];
  logic [WORD_W-1:0] rd_acc;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wr_en && sel[i]) mem[i] <= wr_word;
    end
  end

  always_comb begin
    rd_acc = '0;
    for (int i = 0; i < NUM_CELLS; i++) begin
      rd_acc = rd_acc | (mem[i] & {WORD_W{sel[i]}});
    end
  end

  assign rd_word = cell_word_t'(rd_acc);

  // R5: a write targets exactly one cell
  a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $onehot(sel));
endmodule

// File: rtl/line_cell_buffer.sv
module line_cell_buffer
  import lcb_pkg::*;
#(
  parameter int NUM_CELLS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  logic              fetch_en,
  input  logic              row_start,
  input  logic              advance,
  input  logic [WORD_W-1:0] bus_data,
  output logic [WORD_W-1:0] cell_out
);
  logic [NUM_CELLS-1:0] token;
  logic                 any_sel;
  logic                 wr_en;
  cell_word_t           stored;

  lcb_token_ring #(.NUM_CELLS(NUM_CELLS)) u_ring (
    .clk(clk), .rst_n(rst_n), .ce(pix_ce),
    .restart(row_start), .step(advance), .token(token)
  );

  assign any_sel = |token;
  assign wr_en   = pix_ce && fetch_en && any_sel;

  lcb_cell_array #(.NUM_CELLS(NUM_CELLS)) u_cells (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(token),
    .wr_word(cell_word_t'(bus_data)), .rd_word(stored)
  );

  always_comb begin
    if (wr_en) cell_out = bus_data;
    else       cell_out = stored;
  end

  // R4: nothing selected gives a zero output
  a_r4_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
    !any_sel |-> cell_out == '0);
  // R5/R7: a word written and kept selected is read back
  a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !advance && !row_start |=> wr_en || cell_out == $past(bus_data));
endmodule

// File: tb/tb_line_cell_buffer.sv
`timescale 1ns/1ps
module tb_line_cell_buffer;
  localparam int N = 40;
  logic clk = 1'b0;
  logic rst_n;
  logic pix_ce, fetch_en, row_start, advance;
  logic [11:0] bus_data;
  logic [11:0] cell_out;

  int checks = 0;
  int errors = 0;
  logic [11:0] exp_q [$];
  string       tag_q [$];
  logic [11:0] model [N];
  int          idx;
  bit          done = 0;

  always #2.5 clk = ~clk;

  line_cell_buffer #(.NUM_CELLS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .fetch_en(fetch_en),
    .row_start(row_start), .advance(advance), .bus_data(bus_data),
    .cell_out(cell_out)
  );

  // driver: applies one cycle at the falling edge, pushes the expected output
  task automatic step(input bit ce, input bit fe, input bit rs, input bit adv,
                      input logic [11:0] d, input string tag);
    logic [11:0] e;
    bit wr;
    @(negedge clk);
    pix_ce = ce; fetch_en = fe; row_start = rs; advance = adv; bus_data = d;
    wr = ce && fe && (idx < N);
    if (wr)           e = d;
    else if (idx < N) e = model[idx];
    else              e = 12'h000;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (ce) begin
      if (wr) model[idx] = d;
      if (rs)                  idx = 0;
      else if (adv && idx < N) idx = idx + 1;
    end
  endtask

  // monitor: samples after the falling edge and compares
  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [11:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (cell_out !== e) begin
        errors++;
        $display("FAIL %s: cell_out=%h expected=%h", t, cell_out, e);
      end
    end
  end

  function automatic logic [11:0] pat(int i, int salt);
    return 12'((i * 37 + salt * 11 + 5) ^ (salt << 6));
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idx = 0;
    for (int i = 0; i < N; i++) model[i] = 12'h000;
    rst_n = 1'b0; pix_ce = 0; fetch_en = 0; row_start = 0; advance = 0; bus_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: first write after reset lands in column 0 and reads back
    step(1, 1, 0, 0, 12'hABC, "R6 write-through after reset");
    step(1, 0, 0, 0, 12'h000, "R1 column 0 after reset");
    // fetch line: every column written while advancing
    step(1, 0, 1, 0, 12'h000, "R3 row start");
    for (int i = 0; i < N; i++) step(1, 1, 0, 1, pat(i, 1), "R6 write-through on fetch line");
    // R4: past the end, writes ignored, output zero
    step(1, 1, 0, 0, 12'hFFF, "R4 write ignored past last column");
    step(1, 0, 0, 1, 12'h000, "R4 no wrap on advance");
    step(1, 0, 0, 1, 12'h000, "R4 still empty");
    // reuse line with disabled cycles interleaved
    step(1, 0, 1, 1, 12'h000, "R3 row start wins over advance");
    for (int i = 0; i < N; i++) begin
      step(1, 0, 0, 1, 12'h555, "R7 readback unchanged");
      if (i % 7 == 3) begin
        step(0, 1, 1, 1, 12'h0F0, "R8 disabled cycle no effect");
        step(0, 1, 0, 1, 12'h0F0, "R8 disabled cycle no effect");
      end
    end
    // partial refetch with stalls, restart mid-row
    step(1, 0, 1, 0, 12'h000, "R3 row start");
    for (int i = 0; i < 10; i++) begin
      step(1, 1, 0, 0, pat(i, 2), "R5 stalled write");
      step(1, 1, 0, 1, pat(i, 3), "R5 overwrite same column");
    end
    for (int i = 10; i < 20; i++) step(1, 0, 0, 1, 12'h000, "R7 untouched columns");
    step(1, 0, 1, 1, 12'h000, "R3 restart mid row");
    for (int i = 0; i < N; i++) step(1, 0, 0, 1, 12'h000, "R5 R7 readback of mixed row");
    step(1, 1, 0, 1, 12'h3C3, "R4 empty after full row");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule